// File: doc/BRIEF.md
# Ethernet Destination Address Filter

This block decides whether a received Ethernet frame should be kept, judging only its 48-bit destination address. It keeps a table of 16 perfect-match station addresses. Software fills the table by streaming a setup frame into the block one byte at a time, with markers on the first and last byte. The table is replaced only if the frame turns out to be exactly 192 bytes long. Each 12-byte slot of the setup frame carries one address, spread over six fixed byte offsets.

A compare request carries a destination address and the four mode bits: promiscuous, receive-all, pass-all-multicast and inverse filtering. The block compares the address against the table several entries per cycle, so the latency is fixed. It then reports accept or reject with two flags. The filtering-failed flag means the frame was let through only because of promiscuous or receive-all mode. The multicast flag means it was let through only because of pass-all-multicast mode. The receive path never offers a frame shorter than 14 bytes for a decision.

Top module: `af_addr_filter`

## Requirements
- R1: A setup frame of exactly 192 bytes loads all 16 entries. Entry n comes from setup bytes 12n..12n+11, and its address bytes 0 to 5 are taken from slot offsets 0, 1, 4, 5, 8 and 9. Address byte k sits at bits [8k+7:8k] of an entry and of `req_addr_i`, and byte 0 is the first byte on the wire. The table takes the new contents at most three cycles after the last byte.
- R2: A setup frame of any other length, shorter or longer, leaves the table unchanged.
- R3: The all-ones broadcast address is always accepted, with both flags clear, whatever the modes are.
- R4: With promiscuous or receive-all mode on, every non-broadcast address is accepted, the filtering-failed flag is set and the multicast flag is clear.
- R5: With pass-all-multicast on, and neither of the R4 modes on, an address whose bit 0 is 1 (the group bit of byte 0) is accepted with the multicast flag set and the filtering-failed flag clear.
- R6: When none of R3 to R5 applies, the address is accepted only if it equals a table entry, and both flags are clear.
- R7: In the R6 case, inverse mode inverts the match result.
- R8: The checks are applied in a fixed priority: broadcast first, then promiscuous or receive-all, then multicast, then perfect or inverse matching. At most one flag is set in any result.
- R9: A request is taken when `req_valid_i` and `req_ready_o` are both high. The mode inputs are sampled at that same edge. `req_ready_o` stays low until the result is ready. `resp_valid_o` pulses for one cycle exactly ENTRIES/LANES cycles after the request was taken (4 with the default parameters).
- R10: Reset clears every table entry to zero, clears both flags and the accept output, drives `resp_valid_o` low and drives `req_ready_o` high.
- R11: The accept output and both flags hold their values between responses.
- R12: Setup bytes that arrive without a frame having been started are ignored. A start marker in the middle of a setup frame drops the partial frame and restarts the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| setup_valid_i | input | 1 | A setup byte is present |
| setup_first_i | input | 1 | Marks the first byte of a setup frame |
| setup_last_i | input | 1 | Marks the last byte of a setup frame |
| setup_byte_i | input | 8 | Setup frame byte |
| req_valid_i | input | 1 | Compare request |
| req_addr_i | input | 48 | Destination address, byte 0 in bits [7:0] |
| promisc_i | input | 1 | Promiscuous mode |
| rx_all_i | input | 1 | Receive-all mode |
| all_mcast_i | input | 1 | Pass-all-multicast mode |
| inverse_i | input | 1 | Inverse perfect filtering |
| req_ready_o | output | 1 | Block can take a request |
| resp_valid_o | output | 1 | One-cycle pulse when a result is ready |
| resp_accept_o | output | 1 | Frame accepted |
| resp_filt_fail_o | output | 1 | Accepted only because of promiscuous or receive-all mode |
| resp_mcast_o | output | 1 | Accepted only because of pass-all-multicast mode |

## Verification
The assertions assume that a setup frame is never being committed while a compare is in flight. If that happened, the entries scanned early and late in the compare could come from different tables. The stimulus therefore finishes each setup frame and waits a few idle cycles before it issues the next request. The assertions also assume that requests are only offered through the ready handshake. The bench drives one request at a time and waits for each response, and it changes the address and mode inputs while the block is busy to show that they are captured only at the request edge.

// File: rtl/af_pkg.sv
package af_pkg;
  localparam int unsigned MAC_W      = 48;
  localparam int unsigned SLOT_BYTES = 12;

  typedef logic [MAC_W-1:0] mac_t;

  typedef struct packed {
    logic accept;
    logic filt_fail;
    logic mcast;
  } verdict_t;

  // setup slot offset -> {valid, address byte position}
  function automatic logic [3:0] off_to_lane(input logic [3:0] off);
    case (off)
      4'd0:    return 4'b1_000;
      4'd1:    return 4'b1_001;
      4'd4:    return 4'b1_010;
      4'd5:    return 4'b1_011;
      4'd8:    return 4'b1_100;
      4'd9:    return 4'b1_101;
      default: return 4'b0_000;
    endcase
  endfunction

  function automatic verdict_t decide(input logic bcast, input logic promisc,
                                      input logic rx_all, input logic all_mc,
                                      input logic inverse, input logic grp,
                                      input logic hit);
    verdict_t v;
    v = '0;
    if (bcast) begin
      v.accept = 1'b1;
    end else if (promisc || rx_all) begin
      v.accept    = 1'b1;
      v.filt_fail = 1'b1;
    end else if (all_mc && grp) begin
      v.accept = 1'b1;
      v.mcast  = 1'b1;
    end else begin
      v.accept = hit ^ inverse;
    end
    return v;
  endfunction
endpackage

// File: rtl/af_setup_loader.sv
module af_setup_loader
  import af_pkg::*;
#(
  parameter int unsigned ENTRIES = 16
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     valid_i,
  input  logic                     first_i,
  input  logic                     last_i,
  input  logic [7:0]               byte_i,
  output logic                     commit_o,
  output mac_t [ENTRIES-1:0]       stage_o
);
  localparam int unsigned SETUP_LEN = ENTRIES * SLOT_BYTES;
  localparam int unsigned CNT_MAX   = SETUP_LEN + 1;
  localparam int unsigned CNT_W     = $clog2(CNT_MAX + 1);
  localparam int unsigned SLOT_W    = $clog2(ENTRIES + 1);
  localparam int unsigned IDX_W     = $clog2(ENTRIES);

  logic              active_q;
  logic [CNT_W-1:0]  cnt_q, cur_cnt, cnt_nx;
  logic [SLOT_W-1:0] slot_q, cur_slot, slot_nx;
  logic [3:0]        off_q, cur_off, off_nx;
  logic [3:0]        lane;
  logic              take, wr_en, done;
  mac_t [ENTRIES-1:0] stage_q;

  always_comb begin
    take     = valid_i && (first_i || active_q);
    cur_cnt  = first_i ? '0 : cnt_q;
    cur_slot = first_i ? '0 : slot_q;
    cur_off  = first_i ? '0 : off_q;
    cnt_nx   = (cur_cnt == CNT_W'(CNT_MAX)) ? cur_cnt : cur_cnt + 1'b1;
    if (cur_off == 4'(SLOT_BYTES - 1)) begin
      off_nx  = '0;
      slot_nx = (cur_slot == SLOT_W'(ENTRIES)) ? cur_slot : cur_slot + 1'b1;
    end else begin
      off_nx  = cur_off + 1'b1;
      slot_nx = cur_slot;
    end
    lane  = off_to_lane(cur_off);
    wr_en = take && lane[3] && (cur_slot < SLOT_W'(ENTRIES));
    done  = take && last_i && (cnt_nx == CNT_W'(SETUP_LEN));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
      slot_q   <= '0;
      off_q    <= '0;
      commit_o <= 1'b0;
      stage_q  <= '0;
    end else begin
      commit_o <= done;
      if (take) begin
        active_q <= !last_i;
        cnt_q    <= cnt_nx;
        slot_q   <= slot_nx;
        off_q    <= off_nx;
      end
      if (wr_en) stage_q[cur_slot[IDX_W-1:0]][8*lane[2:0] +: 8] <= byte_i;
    end
  end

  assign stage_o = stage_q;
endmodule

// File: rtl/af_entry_table.sv
module af_entry_table
  import af_pkg::*;
#(
  parameter int unsigned ENTRIES = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               load_i,
  input  mac_t [ENTRIES-1:0] data_i,
  output mac_t [ENTRIES-1:0] entries_o
);
  mac_t [ENTRIES-1:0] tbl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     tbl_q <= '0;
    else if (load_i) tbl_q <= data_i;
  end

  assign entries_o = tbl_q;
endmodule

// File: rtl/af_match_engine.sv
module af_match_engine
  import af_pkg::*;
#(
  parameter int unsigned ENTRIES = 16,
  parameter int unsigned LANES   = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  mac_t               addr_i,
  input  mac_t [ENTRIES-1:0] entries_i,
  output logic               busy_o,
  output logic               final_o,
  output logic               hit_o
);
  localparam int unsigned STEPS  = ENTRIES / LANES;
  localparam int unsigned STEP_W = (STEPS > 1) ? $clog2(STEPS) : 1;
  localparam int unsigned IDX_W  = $clog2(ENTRIES);

  logic              busy_q;
  logic [STEP_W-1:0] step_q;
  mac_t              addr_q;
  logic              acc_q;
  logic [LANES-1:0]  lane_hit;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [IDX_W-1:0] idx;
    assign idx         = IDX_W'(32'(step_q) * LANES + l);
    assign lane_hit[l] = (entries_i[idx] == addr_q);
  end

  assign busy_o  = busy_q;
  assign final_o = busy_q && (step_q == STEP_W'(STEPS - 1));
  assign hit_o   = acc_q || (|lane_hit);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      step_q <= '0;
      addr_q <= '0;
      acc_q  <= 1'b0;
    end else if (!busy_q) begin
      if (start_i) begin
        busy_q <= 1'b1;
        step_q <= '0;
        addr_q <= addr_i;
        acc_q  <= 1'b0;
      end
    end else begin
      acc_q <= hit_o;
      if (final_o) busy_q <= 1'b0;
      else         step_q <= step_q + 1'b1;
    end
  end
endmodule

// File: rtl/af_addr_filter.sv
module af_addr_filter
  import af_pkg::*;
#(
  parameter int unsigned ENTRIES = 16,
  parameter int unsigned LANES   = 4
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        setup_valid_i,
  input  logic        setup_first_i,
  input  logic        setup_last_i,
  input  logic [7:0]  setup_byte_i,
  input  logic        req_valid_i,
  input  logic [47:0] req_addr_i,
  input  logic        promisc_i,
  input  logic        rx_all_i,
  input  logic        all_mcast_i,
  input  logic        inverse_i,
  output logic        req_ready_o,
  output logic        resp_valid_o,
  output logic        resp_accept_o,
  output logic        resp_filt_fail_o,
  output logic        resp_mcast_o
);
  logic               commit;
  mac_t [ENTRIES-1:0] stage, entries;
  logic               eng_busy, eng_final, eng_hit, req_fire;
  logic               pr_q, ra_q, amc_q, inv_q, bc_q, grp_q;
  verdict_t           verdict;

  af_setup_loader #(.ENTRIES(ENTRIES)) u_loader (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (setup_valid_i),
    .first_i (setup_first_i),
    .last_i  (setup_last_i),
    .byte_i  (setup_byte_i),
    .commit_o(commit),
    .stage_o (stage)
  );

  af_entry_table #(.ENTRIES(ENTRIES)) u_table (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (commit),
    .data_i   (stage),
    .entries_o(entries)
  );

  af_match_engine #(.ENTRIES(ENTRIES), .LANES(LANES)) u_engine (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (req_fire),
    .addr_i   (req_addr_i),
    .entries_i(entries),
    .busy_o   (eng_busy),
    .final_o  (eng_final),
    .hit_o    (eng_hit)
  );

  assign req_ready_o = !eng_busy;
  assign req_fire    = req_valid_i && !eng_busy;
  assign verdict     = decide(bc_q, pr_q, ra_q, amc_q, inv_q, grp_q, eng_hit);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      {pr_q, ra_q, amc_q, inv_q, bc_q, grp_q} <= '0;
      resp_valid_o     <= 1'b0;
      resp_accept_o    <= 1'b0;
      resp_filt_fail_o <= 1'b0;
      resp_mcast_o     <= 1'b0;
    end else begin
      resp_valid_o <= eng_final;
      if (req_fire) begin
        pr_q  <= promisc_i;
        ra_q  <= rx_all_i;
        amc_q <= all_mcast_i;
        inv_q <= inverse_i;
        bc_q  <= &req_addr_i;
        grp_q <= req_addr_i[0];
      end
      if (eng_final) begin
        resp_accept_o    <= verdict.accept;
        resp_filt_fail_o <= verdict.filt_fail;
        resp_mcast_o     <= verdict.mcast;
      end
    end
  end
endmodule

// File: rtl/af_addr_filter_sva.sv
module af_addr_filter_sva #(
  parameter int unsigned ENTRIES = 16,
  parameter int unsigned LANES   = 4
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        req_valid_i,
  input logic [47:0] req_addr_i,
  input logic        promisc_i,
  input logic        rx_all_i,
  input logic        all_mcast_i,
  input logic        req_ready_o,
  input logic        resp_valid_o,
  input logic        resp_accept_o,
  input logic        resp_filt_fail_o,
  input logic        resp_mcast_o
);
  localparam int unsigned STEPS = ENTRIES / LANES;
  localparam int unsigned LAT_W = $clog2(STEPS + 2) + 1;

  logic             fire, pend_q, bc_q, pr_q, mc_q;
  logic [LAT_W-1:0] lat_q;

  assign fire = req_valid_i && req_ready_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      lat_q  <= '0;
      bc_q   <= 1'b0;
      pr_q   <= 1'b0;
      mc_q   <= 1'b0;
    end else if (fire) begin
      pend_q <= 1'b1;
      lat_q  <= '0;
      bc_q   <= &req_addr_i;
      pr_q   <= promisc_i || rx_all_i;
      mc_q   <= all_mcast_i && req_addr_i[0];
    end else begin
      if (resp_valid_o) pend_q <= 1'b0;
      if (pend_q && lat_q != {LAT_W{1'b1}}) lat_q <= lat_q + 1'b1;
    end
  end

  p_latency_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resp_valid_o |-> (pend_q && lat_q == LAT_W'(STEPS)));
  p_busy_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire |=> !req_ready_o);
  p_pulse_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resp_valid_o |=> !resp_valid_o);
  p_bcast_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (resp_valid_o && bc_q) |-> (resp_accept_o && !resp_filt_fail_o && !resp_mcast_o));
  p_promisc_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (resp_valid_o && !bc_q && pr_q) |-> (resp_accept_o && resp_filt_fail_o && !resp_mcast_o));
  p_mcast_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (resp_valid_o && !bc_q && !pr_q && mc_q) |-> (resp_accept_o && resp_mcast_o && !resp_filt_fail_o));
  p_noflag_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (resp_valid_o && !bc_q && !pr_q && !mc_q) |-> (!resp_filt_fail_o && !resp_mcast_o));
  p_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !resp_valid_o |-> $stable({resp_accept_o, resp_filt_fail_o, resp_mcast_o}));
endmodule

bind af_addr_filter af_addr_filter_sva #(.ENTRIES(ENTRIES), .LANES(LANES)) u_sva (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .req_valid_i     (req_valid_i),
  .req_addr_i      (req_addr_i),
  .promisc_i       (promisc_i),
  .rx_all_i        (rx_all_i),
  .all_mcast_i     (all_mcast_i),
  .req_ready_o     (req_ready_o),
  .resp_valid_o    (resp_valid_o),
  .resp_accept_o   (resp_accept_o),
  .resp_filt_fail_o(resp_filt_fail_o),
  .resp_mcast_o    (resp_mcast_o)
);

// File: tb/tb_af_addr_filter.sv
module tb_af_addr_filter;
  localparam int STEPS = 4;
  localparam logic [47:0] BCAST = 48'hFFFF_FFFF_FFFF;

  logic        clk = 1'b0;
  logic        rst_ni;
  logic        setup_valid_i, setup_first_i, setup_last_i;
  logic [7:0]  setup_byte_i;
  logic        req_valid_i;
  logic [47:0] req_addr_i;
  logic        promisc_i, rx_all_i, all_mcast_i, inverse_i;
  logic        req_ready_o, resp_valid_o, resp_accept_o, resp_filt_fail_o, resp_mcast_o;

  int          checks = 0;
  int          errors = 0;
  logic [47:0] exp_tbl [16];
  logic [7:0]  fr [256];

  always #10 clk = ~clk;

  af_addr_filter dut (
    .clk_i(clk), .rst_ni(rst_ni),
    .setup_valid_i(setup_valid_i), .setup_first_i(setup_first_i),
    .setup_last_i(setup_last_i), .setup_byte_i(setup_byte_i),
    .req_valid_i(req_valid_i), .req_addr_i(req_addr_i),
    .promisc_i(promisc_i), .rx_all_i(rx_all_i),
    .all_mcast_i(all_mcast_i), .inverse_i(inverse_i),
    .req_ready_o(req_ready_o), .resp_valid_o(resp_valid_o),
    .resp_accept_o(resp_accept_o), .resp_filt_fail_o(resp_filt_fail_o),
    .resp_mcast_o(resp_mcast_o)
  );

  task automatic chk(input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic exp_hit(input logic [47:0] a);
    for (int n = 0; n < 16; n++) if (exp_tbl[n] == a) return 1'b1;
    return 1'b0;
  endfunction

  // m = {promisc, rx_all, all_mcast, inverse}; result = {accept, filt_fail, mcast}
  function automatic logic [2:0] exp_dec(input logic [47:0] a, input logic [3:0] m);
    if (a == BCAST)           return 3'b100;
    if (m[3] || m[2])         return 3'b110;
    if (m[1] && a[0])         return 3'b101;
    return {exp_hit(a) ^ m[0], 2'b00};
  endfunction

  function automatic string rule_of(input logic [47:0] a, input logic [3:0] m);
    if (a == BCAST)   return "R3";
    if (m[3] || m[2]) return "R4";
    if (m[1] && a[0]) return "R5";
    if (m[0])         return "R7";
    return "R6";
  endfunction

  task automatic new_frame();
    for (int i = 0; i < 256; i++) fr[i] = 8'($urandom);
  endtask

  task automatic load_model();
    for (int n = 0; n < 16; n++)
      exp_tbl[n] = {fr[12*n+9], fr[12*n+8], fr[12*n+5], fr[12*n+4], fr[12*n+1], fr[12*n]};
  endtask

  function automatic logic [47:0] frame_entry(input int n);
    return {fr[12*n+9], fr[12*n+8], fr[12*n+5], fr[12*n+4], fr[12*n+1], fr[12*n]};
  endfunction

  task automatic send_bytes(input int n, input bit with_first, input bit with_last);
    for (int i = 0; i < n; i++) begin
      if ($urandom % 5 == 0) begin
        @(negedge clk);
        setup_valid_i = 1'b0;
        @(posedge clk);
      end
      @(negedge clk);
      setup_valid_i = 1'b1;
      setup_first_i = with_first && (i == 0);
      setup_last_i  = with_last && (i == n - 1);
      setup_byte_i  = fr[i];
      @(posedge clk);
    end
    @(negedge clk);
    setup_valid_i = 1'b0;
    setup_first_i = 1'b0;
    setup_last_i  = 1'b0;
    repeat (4) @(posedge clk);
  endtask

  task automatic query(input logic [47:0] a, input logic [3:0] m, input string tag);
    logic [2:0] e, got;
    string      r;
    int         k;
    e = exp_dec(a, m);
    r = {rule_of(a, m), " ", tag};
    @(negedge clk);
    req_valid_i = 1'b1;
    req_addr_i  = a;
    {promisc_i, rx_all_i, all_mcast_i, inverse_i} = m;
    @(posedge clk);
    @(negedge clk);
    req_valid_i = 1'b0;
    req_addr_i  = {$urandom, $urandom} >> 16;
    {promisc_i, rx_all_i, all_mcast_i, inverse_i} = 4'($urandom);
    chk("R9", "ready low while busy", 64'(req_ready_o), 64'd0);
    k = 0;
    while (!resp_valid_o && k < 40) begin
      @(posedge clk);
      @(negedge clk);
      k++;
    end
    chk("R9", "latency", 64'(k), 64'(STEPS));
    got = {resp_accept_o, resp_filt_fail_o, resp_mcast_o};
    chk(r, "verdict {accept,ff,mf}", 64'(got), 64'(e));
    @(posedge clk);
    @(negedge clk);
    chk("R11", "pulse ends, outputs held",
        64'({resp_valid_o, resp_accept_o, resp_filt_fail_o, resp_mcast_o}), 64'({1'b0, got}));
  endtask

  function automatic logic [47:0] rand_addr();
    logic [47:0] a;
    int          n;
    n = int'($urandom % 16);
    case ($urandom % 5)
      0: a = exp_tbl[n];
      1: a = BCAST;
      2: a = ({$urandom, $urandom} >> 16) | 48'h1;
      3: a = exp_tbl[n] ^ (48'h1 << ($urandom % 48));
      default: a = {$urandom, $urandom} >> 16;
    endcase
    return a;
  endfunction

  function automatic logic [3:0] rand_modes();
    logic [3:0] m;
    for (int b = 0; b < 4; b++) m[b] = ($urandom % 4 == 0);
    return m;
  endfunction

  initial begin
    void'($urandom(32'd20240611));
    rst_ni = 1'b0;
    setup_valid_i = 0; setup_first_i = 0; setup_last_i = 0; setup_byte_i = 0;
    req_valid_i = 0; req_addr_i = 0;
    promisc_i = 0; rx_all_i = 0; all_mcast_i = 0; inverse_i = 0;
    for (int n = 0; n < 16; n++) exp_tbl[n] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R10", "ready after reset", 64'(req_ready_o), 64'd1);
    chk("R10", "resp_valid after reset", 64'(resp_valid_o), 64'd0);
    chk("R10", "outputs after reset",
        64'({resp_accept_o, resp_filt_fail_o, resp_mcast_o}), 64'd0);
    rst_ni = 1'b1;
    repeat (2) @(posedge clk);

    // R10: zeroed table matches the all-zero address only
    query(48'h0, 4'b0000, "R10 zero entry");
    query(48'h0000_0000_0A02, 4'b0000, "R10 nonzero");

    // R3 / R8: broadcast wins over every mode
    query(BCAST, 4'b1111, "R8 bcast all modes");

    // R1: full load
    new_frame();
    send_bytes(192, 1'b1, 1'b1);
    load_model();
    for (int n = 0; n < 16; n++) query(exp_tbl[n], 4'b0000, "R1 entry");

    // R2: short and long frames leave the table alone
    new_frame();
    send_bytes(191, 1'b1, 1'b1);
    query(frame_entry(0), 4'b0000, "R2 short new");
    query(exp_tbl[3], 4'b0000, "R2 short old");
    new_frame();
    send_bytes(193, 1'b1, 1'b1);
    query(frame_entry(5), 4'b0000, "R2 long new");
    query(exp_tbl[7], 4'b0000, "R2 long old");

    // R12: bytes without a start marker are ignored
    new_frame();
    send_bytes(192, 1'b0, 1'b1);
    query(frame_entry(2), 4'b0000, "R12 stray new");
    query(exp_tbl[15], 4'b0000, "R12 stray old");
    // R12: restart in the middle of a frame
    new_frame();
    send_bytes(50, 1'b1, 1'b0);
    new_frame();
    send_bytes(192, 1'b1, 1'b1);
    load_model();
    query(exp_tbl[0], 4'b0000, "R12 restart e0");
    query(exp_tbl[15], 4'b0000, "R12 restart e15");

    // R7 / R8 directed
    query(exp_tbl[4], 4'b0001, "R7 inverse hit");
    query(exp_tbl[4] ^ 48'h0100, 4'b0001, "R7 inverse miss");
    query(exp_tbl[9] | 48'h1, 4'b1010, "R8 promisc over mcast");
    query(48'h0000_0000_0001, 4'b0011, "R8 mcast over inverse");
    query(48'h0000_0000_0002, 4'b0010, "R8 unicast no mcast");
    query(48'h0000_0000_0301, 4'b0100, "R4 rx_all");

    // random phase
    for (int it = 0; it < 360; it++) begin
      if (it % 120 == 119) begin
        new_frame();
        send_bytes(192, 1'b1, 1'b1);
        load_model();
      end
      query(rand_addr(), rand_modes(), "random");
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule